// File: doc/BRIEF.md
# Configurable Synchronous Serial Port

This block is a single-word synchronous serial port that can run as the clock-producing master or as a slave clocked from outside. Software sets it up through four word-wide registers: a format register (word size, clock polarity, clock phase, a stored frame-style field, serial rate), a control register (enable, slave select, slave output disable), a prescale register, and a data register. Writes to the setup fields are only taken while the port is disabled. The intended order is to set all fields first and set the enable bit last.

In master mode, a write to the data register starts one frame. The serial clock is made from the system clock in two stages: an even prescale value, then a second divide by (1 + rate). One bit period is therefore prescale × (1 + rate) system clocks. The port sends the word most-significant bit first and captures the incoming bit stream at the same time. In slave mode, the external clock, frame-select and data inputs pass through synchronizers. The word written to the data register is shifted out while the frame-select input is low. The transmit output can be switched to high impedance through an enable output that goes to the pad.

Top module: `ssp_port`

## Requirements
- R1: After reset the port is disabled. busy, rx_valid and tx_oe are 0, sclk_o is 0 and fss_n_o is 1. The format register reads 0x0007, the control register reads 0x0000 and the prescale register reads 2.
- R2: Register offsets are: addr 0 for format, addr 1 for control, addr 2 for prescale, and addr 3 for data. A write to addr 3 loads the transmit word; a read of addr 3 returns the last received word. Format register fields: bits [3:0] hold word size minus one, and values below 3 are stored as 3. Bits [5:4] hold a stored frame-style code. Bit 6 is clock polarity, bit 7 is clock phase, and bits [15:8] are the serial rate. Control register fields: bit 1 is enable, bit 2 is slave, and bit 3 is slave output disable.
- R3: A prescale write stores the value with bit 0 cleared. If the result is 0, the value 2 is stored instead.
- R4: While the port is enabled, writes to the format and prescale registers are ignored, and so are writes to control bits 2 and 3. The enable bit can always be written.
- R5: In master mode, sclk_o changes every (prescale/2) × (1 + rate) system clocks during a frame. A frame of N bits lasts 2·N times that count, from the data write to the fall of busy. For example, prescale 2 with rate 9 gives a 20-cycle bit period.
- R6: sclk_o idles at the polarity bit, and in slave mode it is held at the polarity bit. A leading edge is one that leaves the idle level. With phase 0, a bit is valid before its leading edge, is sampled on the leading edge, and changes on the trailing edge. With phase 1, a bit changes on the leading edge and is sampled on the trailing edge.
- R7: A master frame has N = size+1 bits, from 4 to 16. It produces exactly 2·N clock edges, sends the word MSB first on tx_o, and holds fss_n_o low while busy.
- R8: rx_data holds the N sampled bits, right-justified, with the first bit received as the MSB. rx_valid is a one-cycle pulse in the cycle in which busy falls after a completed frame.
- R9: busy rises in the cycle after an accepted data write. A data write is ignored while busy is high, including in the cycle in which busy falls.
- R10: tx_oe is 1 when the port is enabled as master, or enabled as slave with output disable clear. It is 0 otherwise.
- R11: In slave mode, a falling edge of fss_n_i starts a frame. The port then shifts on sclk_i edges according to R6, presenting the loaded word MSB first on tx_o. It completes after N samples with an rx_valid pulse.
- R12: Clearing enable during a frame aborts it. busy falls, sclk_o returns to idle, fss_n_o returns high, and no rx_valid pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | BUS_W | Write data |
| rdata | output | BUS_W | Read data for addr |
| busy | output | 1 | Frame in progress |
| rx_valid | output | 1 | One-cycle pulse on completed word |
| rx_data | output | 16 | Last received word |
| sclk_o | output | 1 | Serial clock out (master) |
| fss_n_o | output | 1 | Frame select out, active low |
| tx_o | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Transmit output enable for the pad |
| sclk_i | input | 1 | Serial clock in (slave) |
| fss_n_i | input | 1 | Frame select in, active low (slave) |
| rx_i | input | 1 | Serial receive data |

## Verification
Two events can land on the same cycle: a software write to the data register, and the final clock edge that ends a frame and drops busy. The bench works out the frame length arithmetically from prescale, rate and word size. It then places a second data write exactly on the edge where busy falls, and places another write in the middle of the frame. It judges the outcome by requiring the first word to arrive intact with a single rx_valid pulse, and by requiring busy to stay low afterwards, so no second frame is started. Master frames are swept over every size, all four polarity/phase modes and two divider settings, with the transmit output looped back to the receive input.

// File: rtl/ssp_port.sv
module ssp_port #(
  parameter int BUS_W = 16,
  parameter int SCR_W = 8,
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  output logic             busy,
  output logic             rx_valid,
  output logic [15:0]      rx_data,
  output logic             sclk_o,
  output logic             fss_n_o,
  output logic             tx_o,
  output logic             tx_oe,
  input  logic             sclk_i,
  input  logic             fss_n_i,
  input  logic             rx_i
);
  localparam int WORD_W = 16;
  localparam int CNT_W  = 5;
  localparam int HALF_W = PSC_W - 1;

  logic [3:0]        dss;
  logic [1:0]        fmt;
  logic              pol, pha;
  logic [SCR_W-1:0]  scr;
  logic              en, slv, odis;
  logic [PSC_W-1:0]  psc;

  logic [WORD_W-1:0] txsh, rxsh, rx_word;
  logic              busy_q, rxv_q, sclk_q;
  logic [CNT_W-1:0]  ecnt;
  logic [HALF_W-1:0] pcnt;
  logic [SCR_W-1:0]  scnt;
  logic [2:0]        sck_s, fss_s;
  logic [1:0]        rx_s;

  logic wr0, wr1, wr2, wr3;
  logic m_run, s_run, tick, medge, sedge, bit_edge;
  logic lead, smp, shf, rbit, at_end, done, start_m, start_s, fss_fall;
  logic [WORD_W-1:0] rx_nx;

  assign wr0 = wr_en && addr == 2'd0;
  assign wr1 = wr_en && addr == 2'd1;
  assign wr2 = wr_en && addr == 2'd2;
  assign wr3 = wr_en && addr == 2'd3;

  assign m_run    = en && !slv && busy_q;
  assign s_run    = en && slv && busy_q && !fss_s[1];
  assign tick     = m_run && (pcnt == psc[PSC_W-1:1] - HALF_W'(1));
  assign medge    = tick && (scnt == scr);
  assign sedge    = s_run && (sck_s[1] != sck_s[2]);
  assign bit_edge = medge || sedge;

  assign lead   = !ecnt[0];
  assign smp    = bit_edge && (pha ? !lead : lead);
  assign shf    = bit_edge && (pha ? (lead && ecnt != '0) : !lead);
  assign rbit   = slv ? rx_s[1] : rx_i;
  assign rx_nx  = {rxsh[WORD_W-2:0], rbit};
  assign at_end = ecnt[CNT_W-1:1] == dss;
  assign done   = bit_edge && at_end && (slv ? smp : ecnt[0]);

  assign fss_fall = fss_s[2] && !fss_s[1];
  assign start_m  = wr3 && en && !slv && !busy_q;
  assign start_s  = en && slv && !busy_q && fss_fall;

  assign busy     = busy_q;
  assign rx_valid = rxv_q;
  assign rx_data  = rx_word;
  assign sclk_o   = slv ? pol : sclk_q;
  assign fss_n_o  = !m_run;
  assign tx_o     = txsh[dss];
  assign tx_oe    = en && !(slv && odis);

  always_comb begin
    case (addr)
      2'd0:    rdata = BUS_W'({scr, pha, pol, fmt, dss});
      2'd1:    rdata = BUS_W'({odis, slv, en, 1'b0});
      2'd2:    rdata = BUS_W'(psc);
      default: rdata = BUS_W'(rx_word);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= '0;
      fss_s <= '1;
      rx_s  <= '0;
    end else begin
      sck_s <= {sck_s[1:0], sclk_i};
      fss_s <= {fss_s[1:0], fss_n_i};
      rx_s  <= {rx_s[0], rx_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dss  <= 4'd7;
      fmt  <= '0;
      pol  <= 1'b0;
      pha  <= 1'b0;
      scr  <= '0;
      en   <= 1'b0;
      slv  <= 1'b0;
      odis <= 1'b0;
      psc  <= PSC_W'(2);
    end else begin
      if (wr0 && !en) begin
        dss <= (wdata[3:0] < 4'd3) ? 4'd3 : wdata[3:0];
        fmt <= wdata[5:4];
        pol <= wdata[6];
        pha <= wdata[7];
        scr <= wdata[8 +: SCR_W];
      end
      if (wr1) begin
        en <= wdata[1];
        if (!en) begin
          slv  <= wdata[2];
          odis <= wdata[3];
        end
      end
      if (wr2 && !en)
        psc <= (wdata[PSC_W-1:1] == '0) ? PSC_W'(2) : {wdata[PSC_W-1:1], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt   <= '0;
      scnt   <= '0;
      sclk_q <= 1'b0;
    end else begin
      if (!m_run || tick) pcnt <= '0;
      else                pcnt <= pcnt + HALF_W'(1);
      if (!m_run)         scnt <= '0;
      else if (tick)      scnt <= (scnt == scr) ? '0 : scnt + SCR_W'(1);
      if (!m_run)         sclk_q <= pol;
      else if (medge)     sclk_q <= !sclk_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      rxv_q   <= 1'b0;
      ecnt    <= '0;
      rxsh    <= '0;
      rx_word <= '0;
    end else begin
      rxv_q <= 1'b0;
      if (!en) begin
        busy_q <= 1'b0;
      end else if (start_m || start_s) begin
        busy_q <= 1'b1;
        ecnt   <= '0;
        rxsh   <= '0;
      end else if (busy_q && slv && fss_s[1]) begin
        busy_q <= 1'b0;
      end else if (bit_edge) begin
        ecnt <= ecnt + CNT_W'(1);
        if (smp) rxsh <= rx_nx;
        if (done) begin
          busy_q  <= 1'b0;
          rxv_q   <= 1'b1;
          rx_word <= smp ? rx_nx : rxsh;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                txsh <= '0;
    else if (wr3 && !busy_q)   txsh <= wdata[WORD_W-1:0];
    else if (shf)              txsh <= txsh << 1;
  end

  a_r4_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) |-> $stable({dss, fmt, pol, pha, scr, psc, slv, odis}));

  a_r8_valid_with_end: assert property (@(posedge clk) disable iff (!rst_n)
    rxv_q |-> ($past(busy_q) && !busy_q));

  a_r7_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (ecnt <= {dss, 1'b1}));

  a_r9_start_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_q) && !slv) |-> ($past(wr_en) && $past(addr) == 2'd3));

  a_r12_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy_q);
endmodule

// File: tb/tb_ssp_port.sv
module tb_ssp_port;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0, rdata, rx_data;
  logic        busy, rx_valid, sclk_o, fss_n_o, tx_o, tx_oe;
  logic        sclk_i = 1'b0, fss_n_i = 1'b1, drv_rx = 1'b0, slave_tb = 1'b0, rx_i;

  assign rx_i = slave_tb ? drv_rx : tx_o;

  ssp_port dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .busy(busy), .rx_valid(rx_valid), .rx_data(rx_data), .sclk_o(sclk_o),
    .fss_n_o(fss_n_o), .tx_o(tx_o), .tx_oe(tx_oe), .sclk_i(sclk_i), .fss_n_i(fss_n_i), .rx_i(rx_i));

  int n_chk = 0, n_fail = 0, cycles = 0, rv_cnt = 0;
  int gap = 0, ecount = 0, bad_gap = 0, fss_bad = 0, expH = 1;
  logic pol_tb = 1'b0, pha_tb = 1'b0, prev_s = 1'b0, mbusy = 1'b0, finished = 1'b0;
  logic [15:0] cap = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rx_valid) rv_cnt++;
    if (busy && !mbusy) begin
      gap = 0; ecount = 0; bad_gap = 0; fss_bad = 0; cap = '0; prev_s = sclk_o;
    end else if (busy || mbusy) begin
      gap++;
      if (busy && fss_n_o && !slave_tb) fss_bad++;
      if (sclk_o != prev_s) begin
        ecount++;
        if (gap != expH) bad_gap++;
        gap = 0;
        if ((sclk_o != pol_tb) ^ pha_tb) cap = {cap[14:0], tx_o};
      end
      prev_s = sclk_o;
    end
    mbusy = busy;
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  function automatic logic [15:0] fmt_word(input int md, input int dsz, input int sc);
    return {8'(sc), 1'(md & 1), 1'(md >> 1), 2'b00, 4'(dsz)};
  endfunction

  task automatic setup_master(input int md, input int dsz, input int ps, input int sc);
    wr(2'd1, 16'h0);
    wr(2'd0, fmt_word(md, dsz, sc));
    wr(2'd2, 16'(ps));
    pol_tb = 1'(md >> 1); pha_tb = 1'(md & 1);
    expH = (ps / 2) * (sc + 1);
    wr(2'd1, 16'h2);
  endtask

  task automatic mframe(input int md, input int dsz, input int ps, input int sc, input logic [15:0] w);
    int n = dsz + 1;
    int k = 2 * n * (ps / 2) * (sc + 1);
    int cyc = 0;
    int rv0;
    logic [15:0] mask = 16'((32'h1 << n) - 1);
    setup_master(md, dsz, ps, sc);
    chk(sclk_o == pol_tb, "R6 idle level", sclk_o, pol_tb);
    rv0 = rv_cnt;
    wr(2'd3, w);
    while (busy && cyc < 20000) begin @(negedge clk); cyc++; end
    @(negedge clk);
    chk(cyc == k, "R5 frame length", cyc, k);
    chk(bad_gap == 0, "R5 half period", bad_gap, 0);
    chk(ecount == 2 * n, "R7 edge count", ecount, 2 * n);
    chk((cap & mask) == (w & mask), "R7 R6 MSB-first bits", cap & mask, w & mask);
    chk(fss_bad == 0, "R7 frame select", fss_bad, 0);
    chk(rx_data == (w & mask), "R8 loopback word", rx_data, w & mask);
    chk(rv_cnt == rv0 + 1, "R8 one pulse", rv_cnt - rv0, 1);
  endtask

  task automatic sframe(input int md, input int dsz, input logic [15:0] wtx, input logic [15:0] wrx);
    int n = dsz + 1;
    int rv0;
    logic p = 1'(md >> 1), ph = 1'(md & 1);
    logic [15:0] scap = '0;
    logic [15:0] mask = 16'((32'h1 << n) - 1);
    wr(2'd1, 16'h0);
    wr(2'd0, fmt_word(md, dsz, 0));
    sclk_i = p; fss_n_i = 1'b1; slave_tb = 1'b1;
    wr(2'd1, 16'h6);
    wr(2'd3, wtx);
    chk(tx_o == wtx[dsz], "R11 MSB presented", tx_o, wtx[dsz]);
    chk(sclk_o == p, "R6 slave clock held", sclk_o, p);
    rv0 = rv_cnt;
    fss_n_i = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      if (!ph) begin
        drv_rx = wrx[i];
        repeat (8) @(negedge clk);
        scap = {scap[14:0], tx_o};
        sclk_i = !p;
        repeat (8) @(negedge clk);
        sclk_i = p;
      end else begin
        sclk_i = !p;
        repeat (4) @(negedge clk);
        drv_rx = wrx[i];
        repeat (4) @(negedge clk);
        scap = {scap[14:0], tx_o};
        sclk_i = p;
        repeat (8) @(negedge clk);
      end
    end
    repeat (8) @(negedge clk);
    chk(rx_data == (wrx & mask), "R11 slave receive", rx_data, wrx & mask);
    chk((scap & mask) == (wtx & mask), "R11 slave transmit", scap & mask, wtx & mask);
    chk(rv_cnt == rv0 + 1, "R11 slave pulse", rv_cnt - rv0, 1);
    chk(!busy, "R11 slave done", busy, 0);
    fss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    wr(2'd1, 16'h0);
    slave_tb = 1'b0;
  endtask

  initial begin
    logic [15:0] v;
    int rv0, k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !rx_valid && !tx_oe, "R1 flags", {busy, rx_valid, tx_oe}, 0);
    chk(sclk_o == 1'b0 && fss_n_o == 1'b1, "R1 pins", {sclk_o, fss_n_o}, 1);
    rd(2'd0, v); chk(v == 16'h0007, "R1 format reset", v, 16'h0007);
    rd(2'd1, v); chk(v == 16'h0000, "R1 control reset", v, 0);
    rd(2'd2, v); chk(v == 16'd2, "R1 prescale reset", v, 2);

    // R2 field layout
    wr(2'd0, 16'hC3E5); rd(2'd0, v); chk(v == 16'hC3E5, "R2 format fields", v, 16'hC3E5);
    wr(2'd0, 16'h0001); rd(2'd0, v); chk(v == 16'h0003, "R2 size floor", v, 16'h0003);
    // R3 prescale rules
    wr(2'd2, 16'd7);   rd(2'd2, v); chk(v == 16'd6, "R3 even", v, 6);
    wr(2'd2, 16'd1);   rd(2'd2, v); chk(v == 16'd2, "R3 floor one", v, 2);
    wr(2'd2, 16'd0);   rd(2'd2, v); chk(v == 16'd2, "R3 floor zero", v, 2);
    wr(2'd2, 16'd255); rd(2'd2, v); chk(v == 16'd254, "R3 top", v, 254);

    // R4 lock, R10 output enable
    wr(2'd1, 16'hE); rd(2'd1, v); chk(v == 16'hE, "R2 control fields", v, 16'hE);
    chk(tx_oe == 1'b0, "R10 slave output off", tx_oe, 0);
    wr(2'd0, 16'h1234); rd(2'd0, v); chk(v == 16'h0003, "R4 format locked", v, 16'h0003);
    wr(2'd2, 16'h20);   rd(2'd2, v); chk(v == 16'd254, "R4 prescale locked", v, 254);
    wr(2'd1, 16'h2);    rd(2'd1, v); chk(v == 16'hE, "R4 mode bits locked", v, 16'hE);
    wr(2'd1, 16'h0);    rd(2'd1, v); chk(v == 16'hC, "R4 enable writable", v, 16'hC);
    chk(tx_oe == 1'b0, "R10 disabled off", tx_oe, 0);
    wr(2'd1, 16'h6); chk(tx_oe == 1'b1, "R10 slave output on", tx_oe, 1);
    wr(2'd1, 16'h0); wr(2'd1, 16'h2); chk(tx_oe == 1'b1, "R10 master on", tx_oe, 1);

    // R5 rate example: prescale 2, rate 9
    mframe(3, 7, 2, 9, 16'h005A);
    chk(expH * 2 == 20, "R5 bit period", expH * 2, 20);

    // sweep over modes, sizes and two divider settings
    for (int md = 0; md < 4; md++)
      for (int dsz = 3; dsz < 16; dsz++) begin
        mframe(md, dsz, 2, 0, 16'hA5C3 ^ 16'(dsz * 16'h1111) ^ 16'(md));
        mframe(md, dsz, 4, 1, ~(16'h3C96 + 16'(dsz * 7 + md)));
      end

    // R9 write during frame and on the closing edge
    setup_master(0, 7, 2, 1);
    k = 2 * 8 * 2;
    rv0 = rv_cnt;
    @(negedge clk); wr_en = 1'b1; addr = 2'd3; wdata = 16'h003C;
    @(negedge clk); wr_en = 1'b0;
    chk(busy == 1'b1, "R9 busy rises", busy, 1);
    repeat (4) @(negedge clk);
    wdata = 16'h00FF; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    repeat (k - 6) @(negedge clk);
    chk(busy == 1'b1, "R9 busy in final cycle", busy, 1);
    wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    chk(busy == 1'b0, "R9 frame ended", busy, 0);
    @(negedge clk);
    chk(rx_data == 16'h003C, "R9 word intact", rx_data, 16'h003C);
    chk(rv_cnt == rv0 + 1, "R9 single pulse", rv_cnt - rv0, 1);
    repeat (20) @(negedge clk);
    chk(busy == 1'b0, "R9 no restart", busy, 0);

    // R12 abort
    setup_master(2, 15, 4, 3);
    rv0 = rv_cnt;
    wr(2'd3, 16'hBEEF);
    repeat (40) @(negedge clk);
    wr(2'd1, 16'h0);
    repeat (3) @(negedge clk);
    chk(!busy && sclk_o == 1'b1 && fss_n_o, "R12 abort", {busy, sclk_o, fss_n_o}, 3);
    chk(rv_cnt == rv0, "R12 no pulse", rv_cnt - rv0, 0);

    // R11 slave frames
    for (int md = 0; md < 4; md++) begin
      sframe(md, 7, 16'h00C5, 16'h0093);
      sframe(md, 15, 16'h9A3C, 16'h51E7);
      sframe(md, 3, 16'h000B, 16'h0006);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule